// File: doc/BRIEF.md
# Twisted-Pair Link Integrity Monitor

This block decides whether a 10BASE-T receive link is alive and gates the transceiver's data path on that decision. Its inputs are digitized receive-side events: a strobe for each link pulse seen, a tag giving that pulse's polarity, and a strobe for valid receive data. It also takes a millisecond tick, a configuration bit that turns the link test off, an event that marks reselection of the twisted-pair port, and a synchronous hardware reset.

The monitor has two states, Fail and Pass. It leaves Fail on valid receive data, or on an unbroken run of link pulses that all have the same polarity. It returns to Fail on hardware reset, on port reselection, or when the line stays silent for too long. The outputs are a link-status flag, four enables (transmit, receive, loopback, collision detection), gated copies of the transmit, receive and collision activity indications, and a link-pulse transmit request that is always active. All outputs are registered and change on the same edge as the state.

Top module: `tp_link_monitor`

## Requirements
- R1: After hardware reset `link_up`, all four enables and all three indications are 0.
- R2: In Fail, the RUN_LEN-th (default 6) consecutive link pulse of one polarity moves the monitor to Pass, and `link_up` is 1 after that edge. Five such pulses leave it in Fail. This holds for both polarities (`lp_neg` = 0 positive, 1 negative).
- R3: A link pulse whose polarity differs from the previous pulse restarts the run count at 1.
- R4: In Fail, a single `rx_data_valid` strobe moves the monitor to Pass on the next edge.
- R5: With `link_test_off` = 0, `tx_en`, `rx_en`, `lpbk_en` and `coll_en` equal `link_up`: all 1 in Pass and all 0 in Fail.
- R6: With `link_test_off` = 1, all four enables are 1 from the next edge onward, whatever pulses or data arrive. `link_up` still shows the state.
- R7: `lp_tx_req` is 1 at all times, whatever the state of `link_test_off`.
- R8: A `sw_reset` strobe changes neither the state nor a pulse run that is in progress.
- R9: A `port_sel_evt` strobe forces Fail on the next edge and discards any pulse run in progress, including a pulse in the same cycle.
- R10: In Pass, IDLE_MS (default 100) `ms_tick` strobes with no link pulse and no receive data return the monitor to Fail on the edge of the last tick. Any activity restarts the count.
- R11: `xmt_ind`, `rcv_ind` and `col_ind` follow `xmt_act`, `rcv_act` and `col_act` one cycle later while in Pass, and are 0 in Fail.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| lp_seen | input | 1 | One-cycle strobe: a link pulse was qualified |
| lp_neg | input | 1 | Polarity of the pulse: 0 positive, 1 negative |
| rx_data_valid | input | 1 | One-cycle strobe: valid receive data seen |
| ms_tick | input | 1 | One-cycle strobe each millisecond |
| link_test_off | input | 1 | 1 disables the link test and forces the enables on |
| port_sel_evt | input | 1 | Strobe: the twisted-pair port has been reselected |
| sw_reset | input | 1 | Software reset strobe, no effect on this block |
| xmt_act | input | 1 | Raw transmit activity |
| rcv_act | input | 1 | Raw receive activity |
| col_act | input | 1 | Raw collision activity |
| link_up | output | 1 | Link status, 1 in Pass |
| tx_en | output | 1 | Transmit enable |
| rx_en | output | 1 | Receive enable |
| lpbk_en | output | 1 | Loopback enable |
| coll_en | output | 1 | Collision detect enable |
| xmt_ind | output | 1 | Gated transmit indication |
| rcv_ind | output | 1 | Gated receive indication |
| col_ind | output | 1 | Gated collision indication |
| lp_tx_req | output | 1 | Link pulse transmit request, always 1 |

## Verification
The hardest situation to reach is the idle-timeout boundary in Pass. The line must stay silent for exactly IDLE_MS ticks, and one tick fewer must leave the link up. The bench enters Pass through a data strobe and issues IDLE_MS-1 ticks, then a link pulse to restart the window. It then issues IDLE_MS-1 more ticks and checks that the link is still up, and checks that the next tick drops it. Pulse runs that are cut by a polarity flip or a port reselection are built pulse by pulse, and the bench checks the state after each critical pulse.

// File: rtl/lnkmon_pkg.sv
package lnkmon_pkg;
  typedef enum logic {
    LNK_FAIL = 1'b0,
    LNK_PASS = 1'b1
  } lnk_state_e;

  localparam int NUM_EN  = 4;
  localparam int EN_TX   = 0;
  localparam int EN_RX   = 1;
  localparam int EN_LPBK = 2;
  localparam int EN_COLL = 3;
endpackage

// File: rtl/lnkmon_pulse_run.sv
// Counts consecutive same-polarity link pulses and flags the one completing the run.
module lnkmon_pulse_run #(
  parameter int RUN_LEN = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic pulse,
  input  logic pol,
  output logic run_met
);
  localparam int CW = $clog2(RUN_LEN + 1);

  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          pol_q;

  always_comb begin
    cnt_nxt = cnt_q;
    if (pulse) begin
      if (cnt_q != '0 && pol == pol_q) begin
        if (cnt_q != CW'(RUN_LEN))
          cnt_nxt = cnt_q + CW'(1);
      end else begin
        cnt_nxt = CW'(1);
      end
    end
  end

  assign run_met = pulse && (cnt_nxt == CW'(RUN_LEN));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
      pol_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      if (pulse)
        pol_q <= pol;
    end
  end
endmodule

// File: rtl/lnkmon_idle_timer.sv
// Counts millisecond ticks without line activity while the link is up.
module lnkmon_idle_timer #(
  parameter int IDLE_MS = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic activity,
  input  logic tick,
  output logic expire
);
  localparam int TW = (IDLE_MS < 2) ? 1 : $clog2(IDLE_MS);

  logic [TW-1:0] cnt_q;

  assign expire = run && tick && !activity && (cnt_q == TW'(IDLE_MS - 1));

  always_ff @(posedge clk) begin
    if (rst || !run || activity || expire)
      cnt_q <= '0;
    else if (tick)
      cnt_q <= cnt_q + TW'(1);
  end
endmodule

// File: rtl/lnkmon_out_gate.sv
// Registers the enables and the gated activity indications from the next state.
module lnkmon_out_gate
  import lnkmon_pkg::*;
#(
  parameter int N_EN = NUM_EN
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pass_d,
  input  logic            test_off,
  input  logic            xmt_act,
  input  logic            rcv_act,
  input  logic            col_act,
  output logic [N_EN-1:0] en_q,
  output logic            xmt_q,
  output logic            rcv_q,
  output logic            col_q,
  output logic            req_q
);
  for (genvar i = 0; i < N_EN; i++) begin : g_en
    always_ff @(posedge clk) begin
      if (rst) en_q[i] <= 1'b0;
      else     en_q[i] <= pass_d | test_off;
    end
  end

  always_ff @(posedge clk) begin
    req_q <= 1'b1;
    if (rst) begin
      xmt_q <= 1'b0;
      rcv_q <= 1'b0;
      col_q <= 1'b0;
    end else begin
      xmt_q <= pass_d & xmt_act;
      rcv_q <= pass_d & rcv_act;
      col_q <= pass_d & col_act;
    end
  end
endmodule

// File: rtl/tp_link_monitor.sv
module tp_link_monitor
  import lnkmon_pkg::*;
#(
  parameter int RUN_LEN = 6,
  parameter int IDLE_MS = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic lp_seen,
  input  logic lp_neg,
  input  logic rx_data_valid,
  input  logic ms_tick,
  input  logic link_test_off,
  input  logic port_sel_evt,
  input  logic sw_reset,
  input  logic xmt_act,
  input  logic rcv_act,
  input  logic col_act,
  output logic link_up,
  output logic tx_en,
  output logic rx_en,
  output logic lpbk_en,
  output logic coll_en,
  output logic xmt_ind,
  output logic rcv_ind,
  output logic col_ind,
  output logic lp_tx_req
);
  lnk_state_e state_q, state_d;
  logic run_met, idle_expire, run_clear;
  logic [NUM_EN-1:0] en_vec;
  logic sw_reset_unused;

  // The software reset is deliberately not connected to any state.
  assign sw_reset_unused = sw_reset;

  assign run_clear = (state_q == LNK_PASS) || port_sel_evt;

  lnkmon_pulse_run #(.RUN_LEN(RUN_LEN)) u_run (
    .clk     (clk),
    .rst     (rst),
    .clear   (run_clear),
    .pulse   (lp_seen),
    .pol     (lp_neg),
    .run_met (run_met)
  );

  lnkmon_idle_timer #(.IDLE_MS(IDLE_MS)) u_idle (
    .clk      (clk),
    .rst      (rst),
    .run      (state_q == LNK_PASS),
    .activity (lp_seen | rx_data_valid),
    .tick     (ms_tick),
    .expire   (idle_expire)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      LNK_FAIL: if (rx_data_valid || run_met) state_d = LNK_PASS;
      LNK_PASS: if (idle_expire)              state_d = LNK_FAIL;
      default:                                state_d = LNK_FAIL;
    endcase
    if (port_sel_evt)
      state_d = LNK_FAIL;
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= LNK_FAIL;
    else     state_q <= state_d;
  end

  assign link_up = (state_q == LNK_PASS);

  lnkmon_out_gate #(.N_EN(NUM_EN)) u_gate (
    .clk      (clk),
    .rst      (rst),
    .pass_d   (state_d == LNK_PASS),
    .test_off (link_test_off),
    .xmt_act  (xmt_act),
    .rcv_act  (rcv_act),
    .col_act  (col_act),
    .en_q     (en_vec),
    .xmt_q    (xmt_ind),
    .rcv_q    (rcv_ind),
    .col_q    (col_ind),
    .req_q    (lp_tx_req)
  );

  assign tx_en   = en_vec[EN_TX];
  assign rx_en   = en_vec[EN_RX];
  assign lpbk_en = en_vec[EN_LPBK];
  assign coll_en = en_vec[EN_COLL];
endmodule

// File: rtl/lnkmon_chk.sv
module lnkmon_chk (
  input logic clk,
  input logic rst,
  input logic lp_seen,
  input logic lp_neg,
  input logic rx_data_valid,
  input logic ms_tick,
  input logic link_test_off,
  input logic port_sel_evt,
  input logic sw_reset,
  input logic xmt_act,
  input logic rcv_act,
  input logic col_act,
  input logic link_up,
  input logic tx_en,
  input logic rx_en,
  input logic lpbk_en,
  input logic coll_en,
  input logic xmt_ind,
  input logic rcv_ind,
  input logic col_ind,
  input logic lp_tx_req
);
  // R1
  reset_state_chk: assert property (@(posedge clk) rst |=> (!link_up && !tx_en && !xmt_ind));

  // R4
  data_enters_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (!link_up && rx_data_valid && !port_sel_evt) |=> link_up);

  // R5
  fail_gates_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!link_up && !$past(link_test_off)) |-> (!tx_en && !rx_en && !lpbk_en && !coll_en));

  // R6
  test_off_forces_on_chk: assert property (@(posedge clk) disable iff (rst)
    link_test_off |=> (tx_en && rx_en && lpbk_en && coll_en));

  // R9
  port_sel_fail_chk: assert property (@(posedge clk) disable iff (rst)
    port_sel_evt |=> !link_up);

  // R10
  pass_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (link_up && !ms_tick && !port_sel_evt) |=> link_up);

  // R11
  ind_gated_chk: assert property (@(posedge clk) disable iff (rst)
    (xmt_ind || rcv_ind || col_ind) |-> link_up);
endmodule

bind tp_link_monitor lnkmon_chk u_chk (.*);

// File: tb/tp_link_monitor_tb.sv
module tp_link_monitor_tb;
  logic clk = 1'b0;
  logic rst, lp_seen, lp_neg, rx_data_valid, ms_tick, link_test_off;
  logic port_sel_evt, sw_reset, xmt_act, rcv_act, col_act;
  logic link_up, tx_en, rx_en, lpbk_en, coll_en, xmt_ind, rcv_ind, col_ind, lp_tx_req;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  tp_link_monitor u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; lp_seen = 0; lp_neg = 0; rx_data_valid = 0; ms_tick = 0;
    link_test_off = 0; port_sel_evt = 0; sw_reset = 0;
    xmt_act = 0; rcv_act = 0; col_act = 0;
    cyc(); cyc();
    rst = 0;
    cyc();
  endtask

  task automatic pulse(input logic neg);
    lp_seen = 1; lp_neg = neg; cyc(); lp_seen = 0; cyc();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin ms_tick = 1; cyc(); ms_tick = 0; end
  endtask

  task automatic data_strobe();
    rx_data_valid = 1; cyc(); rx_data_valid = 0;
  endtask

  function automatic logic [3:0] ens();
    return {tx_en, rx_en, lpbk_en, coll_en};
  endfunction

  task automatic t_reset();
    do_reset();
    chk("R1 link_up", link_up, 0);
    chk("R1 enables", ens(), 0);
    chk("R1 indications", {xmt_ind, rcv_ind, col_ind}, 0);
    chk("R7 req after reset", lp_tx_req, 1);
  endtask

  task automatic t_run(input logic neg);
    do_reset();
    for (int i = 0; i < 5; i++) pulse(neg);
    chk("R2 five pulses stay fail", link_up, 0);
    chk("R5 fail enables off", ens(), 0);
    pulse(neg);
    chk("R2 sixth pulse pass", link_up, 1);
    chk("R5 pass enables on", ens(), 4'hf);
  endtask

  task automatic t_pol_flip();
    do_reset();
    for (int i = 0; i < 5; i++) pulse(0);
    for (int i = 0; i < 5; i++) pulse(1);
    chk("R3 flip restarts run", link_up, 0);
    pulse(1);
    chk("R3 new run completes", link_up, 1);
  endtask

  task automatic t_data();
    do_reset();
    data_strobe();
    chk("R4 data enters pass", link_up, 1);
  endtask

  task automatic t_idle();
    do_reset();
    data_strobe();
    ticks(99);
    chk("R10 99 ticks keep pass", link_up, 1);
    pulse(1);
    ticks(99);
    chk("R10 activity restarted count", link_up, 1);
    ticks(1);
    chk("R10 100th tick fails", link_up, 0);
    chk("R5 enables drop on idle", ens(), 0);
  endtask

  task automatic t_port();
    do_reset();
    data_strobe();
    port_sel_evt = 1; cyc(); port_sel_evt = 0;
    chk("R9 reselect forces fail", link_up, 0);
    for (int i = 0; i < 5; i++) pulse(0);
    lp_seen = 1; lp_neg = 0; port_sel_evt = 1; cyc();
    lp_seen = 0; port_sel_evt = 0; cyc();
    chk("R9 sixth pulse with reselect stays fail", link_up, 0);
    pulse(0);
    for (int i = 0; i < 4; i++) pulse(0);
    chk("R9 run discarded", link_up, 0);
    pulse(0);
    chk("R9 fresh run passes", link_up, 1);
  endtask

  task automatic t_sw();
    do_reset();
    data_strobe();
    sw_reset = 1; cyc(); sw_reset = 0; cyc();
    chk("R8 sw reset keeps pass", link_up, 1);
    do_reset();
    for (int i = 0; i < 3; i++) pulse(1);
    sw_reset = 1; cyc(); sw_reset = 0;
    for (int i = 0; i < 2; i++) pulse(1);
    chk("R8 five pulses still fail", link_up, 0);
    pulse(1);
    chk("R8 run survived sw reset", link_up, 1);
  endtask

  task automatic t_test_off();
    do_reset();
    link_test_off = 1; cyc();
    chk("R6 enables forced", ens(), 4'hf);
    chk("R6 link_up shows fail", link_up, 0);
    for (int i = 0; i < 4; i++) pulse(i[0]);
    chk("R6 enables stay on", ens(), 4'hf);
    chk("R7 req with test off", lp_tx_req, 1);
    link_test_off = 0; cyc();
    chk("R5 enables off again", ens(), 0);
  endtask

  task automatic t_ind();
    do_reset();
    xmt_act = 1; rcv_act = 1; col_act = 1; cyc();
    chk("R11 fail gates indications", {xmt_ind, rcv_ind, col_ind}, 0);
    xmt_act = 0; rcv_act = 0; col_act = 0;
    data_strobe();
    xmt_act = 1; cyc(); xmt_act = 0;
    chk("R11 xmt follows", {xmt_ind, rcv_ind, col_ind}, 3'b100);
    rcv_act = 1; cyc(); rcv_act = 0;
    chk("R11 rcv follows", {xmt_ind, rcv_ind, col_ind}, 3'b010);
    col_act = 1; cyc(); col_act = 0;
    chk("R11 col follows", {xmt_ind, rcv_ind, col_ind}, 3'b001);
    cyc();
    chk("R11 idle zero", {xmt_ind, rcv_ind, col_ind}, 3'b000);
  endtask

  initial begin
    t_reset();
    t_run(0);
    t_run(1);
    t_pol_flip();
    t_data();
    t_idle();
    t_port();
    t_sw();
    t_test_off();
    t_ind();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule